// File: doc/BRIEF.md
# Multi-Master I2C Byte Controller

This block is a byte-level I2C master that shares a wired-AND bus with other masters. It never drives a line high. For each line it has one output that, when set, pulls the line low. It reads the real line levels back through two input pins. Those samples drive the bit timing, the check for lost arbitration and the tracking of whether the bus is busy.

The host gives one command at a time: open (START or repeated START), write a byte, read a byte, or close (STOP). To address a slave, the host opens the bus and then writes a byte holding the 7-bit address and the direction bit. The block makes every clock pulse, including the ones used while reading. It follows slaves that hold SCL low. It cuts its high phase short when another master pulls SCL low. If another master wins arbitration, it lets go of both lines at once.

The SCL timing comes from one parameter, `HALF_CYC`. It sets the minimum low time and the minimum high time, counted in system clock cycles. The default of 1000 at a 200 MHz clock keeps the bus at or below 100 kbit/s.

Top module: `i2c_mm_master`

## Requirements
- R1: After reset both line pull-down outputs are 0, `bus_busy` is 0 and `cmd_ready` is 1.
- R2: SDA changes while SCL is high only to form a START (SDA falls, op code 0) or a STOP (SDA rises, op code 3). A START leaves SCL held low. A STOP leaves both lines released.
- R3: A write (op code 1) sends `cmd_data` MSB first, one SCL pulse per bit, then releases SDA for a ninth pulse. `ack_ok` is 1 when SDA was low on that ninth pulse and 0 when it was high.
- R4: A read (op code 2) releases SDA for 8 pulses and shifts the bits MSB first into `rx_data`. On the ninth pulse it pulls SDA low when `cmd_last` is 0 and releases it (NACK) when `cmd_last` is 1.
- R5: After releasing SCL, the block starts counting its high time only once SCL reads high. While a slave holds SCL low, the block waits with no timeout and makes no progress.
- R6: If SCL reads low during the high phase of a data bit, the block ends that high phase and pulls SCL low itself. The bit is not repeated.
- R7: If SDA reads low during the high phase of a write bit in which the block released SDA, the block releases both lines in the same cycle. It pulses `arb_lost` together with `done`, and stops owning the bus.
- R8: `bus_busy` goes to 1 when a START is seen on the lines and back to 0 when a STOP is seen. This applies whether this block or another master made the condition, and also while this block is idle.
- R9: A START command waits, with both lines untouched, while `bus_busy` is 1 and the block does not own the bus. While the block owns the bus, a START is sent straight away as a repeated START.
- R10: Every SCL low period and every SCL high period the block produces lasts at least `HALF_CYC` clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Host command present |
| cmd_op | input | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_data | input | 8 | Byte to send on WRITE |
| cmd_last | input | 1 | On READ: 1 sends NACK, 0 sends ACK |
| cmd_ready | output | 1 | Block can take a command |
| done | output | 1 | One-cycle pulse when a command ends |
| rx_data | output | 8 | Byte captured by the last READ |
| ack_ok | output | 1 | Slave acknowledged the last WRITE |
| arb_lost | output | 1 | Pulse with `done` when arbitration was lost |
| bus_busy | output | 1 | Bus is held between a START and a STOP |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest conditions to reach from the ports depend on the exact phase of the SCL waveform: another master pulling SCL low partway through this block's high phase, and a slave holding SCL low partway through a byte. The bench models the bus as a wired-AND of this block's outputs, a slave model and a second-master model. Stimulus processes wait for a chosen count of SCL rising edges and then grab a line a few clocks into that phase. Arbitration loss is set up by having the rival master hold SDA low before a byte whose first bit is 1. A foreign START is made while the block is idle to test the busy wait.

// File: rtl/i2c_mm_pkg.sv
`timescale 1ns/1ps
package i2c_mm_pkg;

  typedef enum logic [1:0] {
    HOP_START = 2'd0,
    HOP_WRITE = 2'd1,
    HOP_READ  = 2'd2,
    HOP_STOP  = 2'd3
  } host_op_e;

  typedef enum logic [1:0] {
    BIT_START = 2'd0,
    BIT_STOP  = 2'd1,
    BIT_WR    = 2'd2,
    BIT_RD    = 2'd3
  } bit_op_e;

  // SDA falling while SCL stays high
  function automatic logic start_edge(logic sda_prev, logic sda_now,
                                      logic scl_prev, logic scl_now);
    return sda_prev & ~sda_now & scl_prev & scl_now;
  endfunction

  // SDA rising while SCL stays high
  function automatic logic stop_edge(logic sda_prev, logic sda_now,
                                     logic scl_prev, logic scl_now);
    return ~sda_prev & sda_now & scl_prev & scl_now;
  endfunction

  // bit number idx of a byte, counted from the MSB
  function automatic logic byte_bit(logic [7:0] b, logic [3:0] idx);
    return b[3'd7 - idx[2:0]];
  endfunction

  // released SDA seen low on a write bit: another master wins
  function automatic logic arb_hit(bit_op_e op, logic din, logic sda_line);
    return (op == BIT_WR) && din && !sda_line;
  endfunction

endpackage

// File: rtl/i2c_mm_bus_mon.sv
`timescale 1ns/1ps
module i2c_mm_bus_mon
  import i2c_mm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic busy
);
  logic [1:0] scl_ff, sda_ff;
  logic       scl_d, sda_d;
  logic       start_seen, stop_seen;

  assign scl_s      = scl_ff[1];
  assign sda_s      = sda_ff[1];
  assign start_seen = start_edge(sda_d, sda_s, scl_d, scl_s);
  assign stop_seen  = stop_edge(sda_d, sda_s, scl_d, scl_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= 2'b11;
      sda_ff <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
      busy   <= 1'b0;
    end else begin
      scl_ff <= {scl_ff[0], scl_raw};
      sda_ff <= {sda_ff[0], sda_raw};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
      if (start_seen)     busy <= 1'b1;
      else if (stop_seen) busy <= 1'b0;
    end
  end

  assert_busy_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> busy);
  assert_busy_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> !busy);

endmodule

// File: rtl/i2c_mm_bit_engine.sv
`timescale 1ns/1ps
module i2c_mm_bit_engine
  import i2c_mm_pkg::*;
#(
  parameter int unsigned HALF_CYC = 1000
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req,
  input  bit_op_e op,
  input  logic    din,
  input  logic    scl_s,
  input  logic    sda_s,
  output logic    done,
  output logic    dout,
  output logic    lost,
  output logic    scl_oe,
  output logic    sda_oe
);
  localparam int unsigned CW = $clog2(HALF_CYC + 1);

  typedef enum logic [2:0] {E_IDLE, E_LOW, E_RISE, E_HIGH, E_EDGE, E_TAIL} est_e;

  est_e          st;
  bit_op_e       cur_op;
  logic          cur_din;
  logic [CW-1:0] cnt;
  logic          cnt_end, is_data, arb_now, early_low;

  assign cnt_end   = (cnt == CW'(HALF_CYC - 1));
  assign is_data   = (cur_op == BIT_WR) || (cur_op == BIT_RD);
  assign arb_now   = (st == E_HIGH) && arb_hit(cur_op, cur_din, sda_s);
  assign early_low = (st == E_HIGH) && is_data && !scl_s && !arb_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= E_IDLE;
      cur_op  <= BIT_RD;
      cur_din <= 1'b1;
      cnt     <= '0;
      done    <= 1'b0;
      dout    <= 1'b1;
      lost    <= 1'b0;
      scl_oe  <= 1'b0;
      sda_oe  <= 1'b0;
    end else begin
      done <= 1'b0;
      lost <= 1'b0;
      unique case (st)
        E_IDLE: if (req) begin
          cur_op  <= op;
          cur_din <= din;
          cnt     <= '0;
          st      <= E_LOW;
          unique case (op)
            BIT_START: sda_oe <= 1'b0;
            BIT_STOP:  sda_oe <= 1'b1;
            BIT_WR:    sda_oe <= ~din;
            BIT_RD:    sda_oe <= 1'b0;
          endcase
        end
        E_LOW: begin
          if (cnt_end) begin
            cnt    <= '0;
            scl_oe <= 1'b0;
            st     <= E_RISE;
          end else cnt <= cnt + 1'b1;
        end
        E_RISE: if (scl_s) begin
          cnt <= '0;
          st  <= E_HIGH;
        end
        E_HIGH: begin
          if (arb_now) begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            lost   <= 1'b1;
            done   <= 1'b1;
            st     <= E_IDLE;
          end else if (early_low || (cnt_end && is_data)) begin
            scl_oe <= 1'b1;
            dout   <= sda_s;
            done   <= 1'b1;
            st     <= E_IDLE;
          end else if (cnt_end) begin
            cnt    <= '0;
            sda_oe <= (cur_op == BIT_START);
            st     <= E_EDGE;
          end else cnt <= cnt + 1'b1;
        end
        E_EDGE: begin
          if (cnt_end) begin
            cnt <= '0;
            if (cur_op == BIT_START) begin
              scl_oe <= 1'b1;
              st     <= E_TAIL;
            end else begin
              done <= 1'b1;
              st   <= E_IDLE;
            end
          end else cnt <= cnt + 1'b1;
        end
        E_TAIL: begin
          if (cnt_end) begin
            done <= 1'b1;
            st   <= E_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  assert_sda_still_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_HIGH && $past(st) == E_HIGH) |-> $stable(sda_oe));
  assert_stretch_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_RISE && !scl_s) |=> (st == E_RISE && !scl_oe && !done));
  assert_sync_pull_R6: assert property (@(posedge clk) disable iff (!rst_n)
    early_low |=> (scl_oe && done));
  assert_arb_withdraw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arb_now |=> (lost && !scl_oe && !sda_oe));

endmodule

// File: rtl/i2c_mm_byte_ctrl.sv
`timescale 1ns/1ps
module i2c_mm_byte_ctrl
  import i2c_mm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       cmd_last,
  output logic       cmd_ready,
  output logic       done,
  output logic [7:0] rx_data,
  output logic       ack_ok,
  output logic       arb_lost,
  input  logic       bus_busy,
  output logic       bit_req,
  output bit_op_e    bit_op,
  output logic       bit_din,
  input  logic       bit_done,
  input  logic       bit_dout,
  input  logic       bit_lost
);
  typedef enum logic [1:0] {B_IDLE, B_LAUNCH, B_WAIT} bst_e;

  bst_e       st;
  host_op_e   op_q;
  logic [7:0] data_q, shreg;
  logic       last_q, owner;
  logic [3:0] idx;
  bit_op_e    nx_op;
  logic       nx_din, start_blocked, byte_end;

  assign cmd_ready     = (st == B_IDLE);
  assign start_blocked = (st == B_LAUNCH) && (op_q == HOP_START) && bus_busy && !owner;
  assign byte_end      = (st == B_WAIT) && bit_done && !bit_lost && (idx == 4'd8) &&
                         (op_q == HOP_WRITE || op_q == HOP_READ);

  always_comb begin
    nx_op  = BIT_RD;
    nx_din = 1'b1;
    unique case (op_q)
      HOP_START: nx_op = BIT_START;
      HOP_STOP:  nx_op = BIT_STOP;
      HOP_WRITE: if (idx < 4'd8) begin
        nx_op  = BIT_WR;
        nx_din = byte_bit(data_q, idx);
      end
      HOP_READ: if (idx == 4'd8) begin
        nx_op  = BIT_WR;
        nx_din = last_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= B_IDLE;
      op_q     <= HOP_START;
      data_q   <= '0;
      last_q   <= 1'b0;
      idx      <= '0;
      shreg    <= '0;
      owner    <= 1'b0;
      done     <= 1'b0;
      rx_data  <= '0;
      ack_ok   <= 1'b0;
      arb_lost <= 1'b0;
      bit_req  <= 1'b0;
      bit_op   <= BIT_RD;
      bit_din  <= 1'b1;
    end else begin
      bit_req  <= 1'b0;
      done     <= 1'b0;
      arb_lost <= 1'b0;
      unique case (st)
        B_IDLE: if (cmd_valid) begin
          op_q   <= host_op_e'(cmd_op);
          data_q <= cmd_data;
          last_q <= cmd_last;
          idx    <= '0;
          st     <= B_LAUNCH;
        end
        B_LAUNCH: if (!start_blocked) begin
          bit_req <= 1'b1;
          bit_op  <= nx_op;
          bit_din <= nx_din;
          st      <= B_WAIT;
        end
        B_WAIT: if (bit_done) begin
          if (bit_lost) begin
            owner    <= 1'b0;
            arb_lost <= 1'b1;
            done     <= 1'b1;
            st       <= B_IDLE;
          end else if (op_q == HOP_START || op_q == HOP_STOP) begin
            owner <= (op_q == HOP_START);
            done  <= 1'b1;
            st    <= B_IDLE;
          end else if (idx == 4'd8) begin
            if (op_q == HOP_WRITE) ack_ok <= ~bit_dout;
            else                   rx_data <= shreg;
            done <= 1'b1;
            st   <= B_IDLE;
          end else begin
            shreg <= {shreg[6:0], bit_dout};
            idx   <= idx + 4'd1;
            st    <= B_LAUNCH;
          end
        end
        default: st <= B_IDLE;
      endcase
    end
  end

  assert_no_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_blocked |=> !bit_req);
  assert_byte_closes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    byte_end |=> (done && cmd_ready));

endmodule

// File: rtl/i2c_mm_master.sv
`timescale 1ns/1ps
module i2c_mm_master
  import i2c_mm_pkg::*;
#(
  parameter int unsigned HALF_CYC = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic [7:0] cmd_data,
  input  logic       cmd_last,
  output logic       cmd_ready,
  output logic       done,
  output logic [7:0] rx_data,
  output logic       ack_ok,
  output logic       arb_lost,
  output logic       bus_busy,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic    scl_s, sda_s;
  logic    bit_req, bit_din, bit_done, bit_dout, bit_lost;
  bit_op_e bit_op;

  i2c_mm_bus_mon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_i), .sda_raw(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .busy(bus_busy)
  );

  i2c_mm_bit_engine #(.HALF_CYC(HALF_CYC)) u_bit (
    .clk(clk), .rst_n(rst_n), .req(bit_req), .op(bit_op), .din(bit_din),
    .scl_s(scl_s), .sda_s(sda_s), .done(bit_done), .dout(bit_dout),
    .lost(bit_lost), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  i2c_mm_byte_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_last(cmd_last), .cmd_ready(cmd_ready),
    .done(done), .rx_data(rx_data), .ack_ok(ack_ok), .arb_lost(arb_lost),
    .bus_busy(bus_busy), .bit_req(bit_req), .bit_op(bit_op), .bit_din(bit_din),
    .bit_done(bit_done), .bit_dout(bit_dout), .bit_lost(bit_lost)
  );

  assert_lost_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (done && !scl_oe && !sda_oe));

endmodule

// File: tb/sim_i2c_mm_master.sv
`timescale 1ns/1ps
module sim_i2c_mm_master;
  localparam int HALF = 8;
  localparam logic [1:0] OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       cmd_valid = 1'b0, cmd_last = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_data = 8'h00;
  logic       cmd_ready, done, ack_ok, arb_lost, bus_busy, scl_oe, sda_oe;
  logic [7:0] rx_data;

  logic slv_scl_hold = 1'b0, slv_sda_low = 1'b0, oth_scl_hold = 1'b0, oth_sda_low = 1'b0;
  wire  scl_w = ~(scl_oe | slv_scl_hold | oth_scl_hold);
  wire  sda_w = ~(sda_oe | slv_sda_low | oth_sda_low);

  i2c_mm_master #(.HALF_CYC(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_last(cmd_last), .cmd_ready(cmd_ready), .done(done),
    .rx_data(rx_data), .ack_ok(ack_ok), .arb_lost(arb_lost), .bus_busy(bus_busy),
    .scl_i(scl_w), .sda_i(sda_w), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc++;

  // slave model and line observers
  int         nrise = 0, n_start = 0, n_stop = 0;
  logic [8:0] cap = '0;
  logic       slv_on = 1'b0, slv_rd = 1'b0, slv_ack = 1'b0;
  logic [7:0] slv_tx = '0;
  bit         meas_en = 1'b0;
  int         t_up = 0, t_dn = 0, min_hi = 99999, min_lo = 99999;

  always @(posedge scl_w) begin
    nrise++;
    cap = {cap[7:0], sda_w};
    if (meas_en && (cyc - t_dn) < min_lo) min_lo = cyc - t_dn;
    t_up = cyc;
  end
  always @(negedge scl_w) begin
    if (meas_en && (cyc - t_up) < min_hi) min_hi = cyc - t_up;
    t_dn = cyc;
    if (slv_on) begin
      if (slv_rd) slv_sda_low = (nrise < 8) ? ~slv_tx[7 - nrise] : 1'b0;
      else        slv_sda_low = (nrise == 8) && slv_ack;
    end
  end
  always @(negedge sda_w) if (scl_w) n_start++;
  always @(posedge sda_w) if (scl_w) n_stop++;

  logic [7:0] r_rx;
  logic       r_ack, r_arb;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [7:0] d, input logic last);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_last = last;
    @(negedge clk);
    cmd_valid = 1'b0;
    do @(negedge clk); while (!done);
    r_rx = rx_data; r_ack = ack_ok; r_arb = arb_lost;
  endtask

  task automatic slave_prep(input logic rd, input logic [7:0] tx, input logic ack);
    nrise = 0; cap = '0; slv_on = 1'b1; slv_rd = rd; slv_tx = tx; slv_ack = ack;
    slv_sda_low = rd ? ~tx[7] : 1'b0;
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    chk("R1", "scl_oe after reset", scl_oe, 0);
    chk("R1", "sda_oe after reset", sda_oe, 0);
    chk("R1", "bus_busy after reset", bus_busy, 0);
    chk("R1", "cmd_ready after reset", cmd_ready, 1);
  endtask

  task automatic t_transfer;
    n_start = 0; n_stop = 0;
    do_cmd(OP_START, 8'h00, 1'b0);
    chk("R2", "start conditions", n_start, 1);
    chk("R2", "scl held low after start", scl_w, 0);
    chk("R8", "busy after own start", bus_busy, 1);
    n_start = 0;
    slave_prep(1'b0, 8'h00, 1'b1);
    min_hi = 99999; min_lo = 99999; meas_en = 1'b1;
    do_cmd(OP_WRITE, 8'hA5, 1'b0);
    meas_en = 1'b0;
    chk("R3", "written byte", cap[8:1], 8'hA5);
    chk("R3", "scl pulses", nrise, 9);
    chk("R3", "ack seen", r_ack, 1);
    chk("R10", "min high >= HALF", (min_hi >= HALF) ? 1 : 0, 1);
    chk("R10", "min low >= HALF", (min_lo >= HALF) ? 1 : 0, 1);
    slave_prep(1'b0, 8'h00, 1'b0);
    do_cmd(OP_WRITE, 8'h3C, 1'b0);
    chk("R3", "nack byte", cap[8:1], 8'h3C);
    chk("R3", "nack seen", r_ack, 0);
    slave_prep(1'b1, 8'h96, 1'b0);
    do_cmd(OP_READ, 8'h00, 1'b0);
    chk("R4", "read byte", r_rx, 8'h96);
    chk("R4", "master ack bit", cap[0], 0);
    chk("R4", "read pulses", nrise, 9);
    slave_prep(1'b1, 8'h5A, 1'b0);
    do_cmd(OP_READ, 8'h00, 1'b1);
    chk("R4", "last read byte", r_rx, 8'h5A);
    chk("R4", "master nack bit", cap[0], 1);
    chk("R2", "no sda edge in scl high during bytes", n_start + n_stop, 0);
    do_cmd(OP_START, 8'h00, 1'b0);
    chk("R9", "repeated start sent while owner", n_start, 1);
    chk("R8", "busy after repeated start", bus_busy, 1);
    n_stop = 0;
    do_cmd(OP_STOP, 8'h00, 1'b0);
    chk("R2", "stop conditions", n_stop, 1);
    repeat (4) @(negedge clk);
    chk("R8", "busy cleared by stop", bus_busy, 0);
    chk("R2", "lines released after stop", scl_oe | sda_oe, 0);
  endtask

  task automatic t_stretch;
    int t0, t1, t2;
    t0 = 0; t1 = 0; t2 = 0;
    do_cmd(OP_START, 8'h00, 1'b0);
    slave_prep(1'b0, 8'h00, 1'b1);
    fork
      do_cmd(OP_WRITE, 8'hC3, 1'b0);
      begin
        wait (nrise == 3);
        @(negedge scl_w);
        slv_scl_hold = 1'b1;
        repeat (300) @(negedge clk);
        chk("R5", "no pulse while held", nrise, 3);
        chk("R5", "not done while held", cmd_ready, 0);
        t0 = cyc;
        slv_scl_hold = 1'b0;
        @(posedge scl_w); t1 = cyc;
        @(negedge scl_w); t2 = cyc;
        chk("R5", "scl rises on release", (t1 - t0 <= 2) ? 1 : 0, 1);
        chk("R5", "full high after release", (t2 - t1 >= HALF) ? 1 : 0, 1);
      end
    join
    chk("R5", "byte through stretch", cap[8:1], 8'hC3);
    chk("R5", "ack through stretch", r_ack, 1);
    do_cmd(OP_STOP, 8'h00, 1'b0);
  endtask

  task automatic t_sync;
    do_cmd(OP_START, 8'h00, 1'b0);
    slave_prep(1'b0, 8'h00, 1'b1);
    fork
      do_cmd(OP_WRITE, 8'h6E, 1'b0);
      begin
        wait (nrise == 2);
        repeat (3) @(negedge clk);
        oth_scl_hold = 1'b1;
        repeat (5) @(negedge clk);
        chk("R6", "block joins low phase", scl_oe, 1);
        oth_scl_hold = 1'b0;
      end
    join
    chk("R6", "byte under sync", cap[8:1], 8'h6E);
    chk("R6", "pulse count under sync", nrise, 9);
    do_cmd(OP_STOP, 8'h00, 1'b0);
  endtask

  task automatic t_arb;
    do_cmd(OP_START, 8'h00, 1'b0);
    slv_on = 1'b0; slv_sda_low = 1'b0; nrise = 0;
    oth_sda_low = 1'b1;
    do_cmd(OP_WRITE, 8'hF0, 1'b0);
    chk("R7", "arb_lost pulse", r_arb, 1);
    chk("R7", "released scl", scl_oe, 0);
    chk("R7", "released sda", sda_oe, 0);
    chk("R7", "withdrew after first bit", nrise, 1);
    repeat (3) @(negedge clk);
    oth_sda_low = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8", "foreign stop clears busy", bus_busy, 0);
  endtask

  task automatic t_busy;
    int touched;
    touched = 0;
    oth_sda_low = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8", "foreign start sets busy while idle", bus_busy, 1);
    fork
      do_cmd(OP_START, 8'h00, 1'b0);
      begin
        repeat (100) begin
          @(negedge clk);
          if (scl_oe || sda_oe) touched++;
        end
        chk("R9", "lines untouched while busy", touched, 0);
        chk("R9", "start still pending", cmd_ready, 0);
        oth_sda_low = 1'b0;
      end
    join
    chk("R9", "start issued after bus freed", bus_busy, 1);
    do_cmd(OP_STOP, 8'h00, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_transfer;
    t_stretch;
    t_sync;
    t_arb;
    t_busy;
    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule